// File: doc/BRIEF.md
# Fabric Clear Handshake Sequencer

This block wipes the contents of an attached programmable-logic fabric before a new configuration image is streamed in. It owns the fabric's active-low program line and watches the fabric's INIT status line. A start pulse runs a three-phase handshake:

- The program line is released and the block waits for INIT high.
- The line is pulled low and the block polls for INIT low.
- The line is released again and the block waits for the INIT rising edge, which marks the end of the fabric's internal initialisation.

Every wait is bounded. The block ends in idle with either a ready flag or an error flag.

All timing comes from an internal prescaler on the system clock. The prescaler makes one poll tick every `TICK_DIV` cycles. The INIT-low poll gives up after `POLL_MAX` ticks. Each wait for INIT high gives up after `TMO_TICKS` ticks. With a 200 MHz clock the defaults give a 5 µs poll spacing, 100 polls and a one-second timeout.

INIT and DONE both pass through two-flop synchronisers. The synchronised DONE is made available to the loader that follows.

Top module: `cfg_clear_seq`

## Requirements
- R1: While reset is held and straight after it, `prog_no` is 1 and `busy_o`, `ready_o` and `err_o` are 0.
- R2: A `start_i` pulse seen in idle makes `busy_o` 1 from the next cycle and clears `ready_o` and `err_o` in that same cycle. `prog_no` stays 1 (released) during the first phase.
- R3: The first phase tests the INIT level rather than an edge. If the synchronised INIT is already high on entry, `prog_no` goes to 0 one cycle after `busy_o` rises.
- R4: `prog_no` is 0 only in the second phase. INIT is checked once every `TICK_DIV` cycles. If INIT is still high after `POLL_MAX` checks, `err_o` rises exactly `POLL_MAX*TICK_DIV` cycles after `prog_no` fell.
- R5: When a check finds INIT low, `prog_no` returns to 1 and the block waits for an INIT rising edge. That edge ends the sequence with `ready_o` = 1, `busy_o` = 0 and `err_o` = 0.
- R6: If INIT has not risen `TMO_TICKS*TICK_DIV` cycles after the first or third phase begins, `err_o` rises, `busy_o` falls and `prog_no` is 1.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The sequence continues and `prog_no` is not disturbed.
- R8: `err_o` stays 1 in idle until the next accepted start, and is 0 in the cycle after that start.
- R9: `ready_o` is 1 only in idle after a successful sequence. It is never 1 together with `busy_o` or `err_o`.
- R10: `done_o` follows `done_i` two clock edges later, and INIT is resynchronised the same way before it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to run the clear sequence |
| init_i | input | 1 | Fabric INIT status, asynchronous |
| done_i | input | 1 | Fabric DONE status, asynchronous |
| prog_no | output | 1 | Fabric program line, active low |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Last sequence completed successfully |
| err_o | output | 1 | Last sequence timed out |
| done_o | output | 1 | Synchronised DONE |

## Verification
The assertions assume that `start_i` is a clean synchronous pulse and that INIT changes no faster than the synchroniser can follow. They also assume that the fabric answers only to transitions of the program line.

The bench's fabric stub drives INIT only from the program line and the busy flag. It applies a programmable delay per phase, and every stimulus change is made on the falling clock edge. The delays in the vector table sit well inside or well outside each window, so that the two-cycle synchroniser latency never decides an outcome.

// File: rtl/cfg_clear_pkg.sv
package cfg_clear_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REL1  = 2'd1,  // line released, wait INIT high (level)
    ST_PULL  = 2'd2,  // line low, poll INIT low
    ST_REL2  = 2'd3   // line released, wait INIT rising edge
  } clr_state_e;
endpackage

// File: rtl/cfg_clear_sync.sv
module cfg_clear_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_clear_tick.sv
module cfg_clear_tick #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  if (DIV > 1) begin : g_spacing
    // R4
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/cfg_clear_fsm.sv
module cfg_clear_fsm
  import cfg_clear_pkg::*;
#(
  parameter int unsigned POLL_MAX  = 100,
  parameter int unsigned TMO_TICKS = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic init_i,
  input  logic tick_i,
  output logic clr_o,
  output logic prog_no,
  output logic busy_o,
  output logic ready_o,
  output logic err_o
);
  localparam int unsigned CNT_MAX = (POLL_MAX > TMO_TICKS) ? POLL_MAX : TMO_TICKS;
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] POLL_LAST = CW'(POLL_MAX - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(TMO_TICKS - 1);

  clr_state_e  state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic        ready_q, ready_n, err_q, err_n;
  logic        init_d_q;
  logic        init_rise;

  assign init_rise = init_i && !init_d_q;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    ready_n = ready_q;
    err_n   = err_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_n = ST_REL1;
        cnt_n   = '0;
        ready_n = 1'b0;
        err_n   = 1'b0;
      end
      ST_REL1: begin
        if (init_i) begin
          state_n = ST_PULL;
          cnt_n   = '0;
        end else if (tick_i) begin
          if (cnt_q == TMO_LAST) begin
            state_n = ST_IDLE;
            err_n   = 1'b1;
          end else cnt_n = cnt_q + 1'b1;
        end
      end
      ST_PULL: if (tick_i) begin
        if (!init_i) begin
          state_n = ST_REL2;
          cnt_n   = '0;
        end else if (cnt_q == POLL_LAST) begin
          state_n = ST_IDLE;
          err_n   = 1'b1;
        end else cnt_n = cnt_q + 1'b1;
      end
      ST_REL2: begin
        if (init_rise) begin
          state_n = ST_IDLE;
          ready_n = 1'b1;
        end else if (tick_i) begin
          if (cnt_q == TMO_LAST) begin
            state_n = ST_IDLE;
            err_n   = 1'b1;
          end else cnt_n = cnt_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ready_q  <= 1'b0;
      err_q    <= 1'b0;
      init_d_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      ready_q  <= ready_n;
      err_q    <= err_n;
      init_d_q <= init_i;
    end
  end

  // restart prescaler on every phase change so each window is exact
  assign clr_o   = (state_n != state_q);
  assign prog_no = (state_q != ST_PULL);
  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = ready_q;
  assign err_o   = err_q;

  // R3
  prog_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_no) |-> ($past(state_q) == ST_REL1 && $past(init_i)));

  // R9
  ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && !err_o));

  // R7
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && state_q != ST_IDLE) |=> (state_q != ST_REL1 || $past(state_q) == ST_REL1));

  // R6
  err_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(busy_o) && !busy_o && prog_no));

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PULL) |-> (cnt_q <= POLL_LAST));
endmodule

// File: rtl/cfg_clear_seq.sv
module cfg_clear_seq #(
  parameter int unsigned TICK_DIV  = 1000,
  parameter int unsigned POLL_MAX  = 100,
  parameter int unsigned TMO_TICKS = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic init_i,
  input  logic done_i,
  output logic prog_no,
  output logic busy_o,
  output logic ready_o,
  output logic err_o,
  output logic done_o
);
  logic [1:0] sync_q;
  logic       clr, tick;

  cfg_clear_sync #(.WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, init_i}),
    .q_o   (sync_q)
  );

  cfg_clear_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .tick_o(tick)
  );

  cfg_clear_fsm #(.POLL_MAX(POLL_MAX), .TMO_TICKS(TMO_TICKS)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .init_i (sync_q[0]),
    .tick_i (tick),
    .clr_o  (clr),
    .prog_no(prog_no),
    .busy_o (busy_o),
    .ready_o(ready_o),
    .err_o  (err_o)
  );

  assign done_o = sync_q[1];
endmodule

// File: tb/cfg_clear_seq_tb.sv
`timescale 1ns/1ps
module cfg_clear_seq_tb;
  localparam int unsigned TICK_DIV  = 4;
  localparam int unsigned POLL_MAX  = 5;
  localparam int unsigned TMO_TICKS = 20;
  localparam logic [15:0] NEVER = 16'hFFFF;
  localparam int NVEC = 7;

  // {init starts high, hi1 delay, lo delay, hi2 delay, expect success}
  localparam logic [49:0] VECS [NVEC] = '{
    {1'b0, 16'd10, 16'd3,  16'd10, 1'b1},
    {1'b1, 16'd10, 16'd3,  16'd10, 1'b1},
    {1'b0, NEVER,  16'd3,  16'd10, 1'b0},
    {1'b0, 16'd10, NEVER,  16'd10, 1'b0},
    {1'b0, 16'd10, 16'd3,  NEVER,  1'b0},
    {1'b0, 16'd30, 16'd10, 16'd60, 1'b1},
    {1'b0, 16'd10, 16'd25, 16'd10, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic done_i = 1'b0;
  logic prog_no, busy_o, ready_o, err_o, done_o;

  // fabric stub
  logic        init_q = 1'b0;
  logic        load = 1'b0, init_start = 1'b0;
  logic [15:0] d_hi1 = 16'd10, d_lo = 16'd3, d_hi2 = 16'd10;
  logic [15:0] cnt = '0, dly = '0;
  logic        tgt = 1'b0, armed = 1'b0, busy_d = 1'b0, prog_d = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  cfg_clear_seq #(.TICK_DIV(TICK_DIV), .POLL_MAX(POLL_MAX), .TMO_TICKS(TMO_TICKS)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .init_i(init_q), .done_i(done_i),
    .prog_no(prog_no), .busy_o(busy_o), .ready_o(ready_o), .err_o(err_o), .done_o(done_o)
  );

  always @(posedge clk_i) begin
    busy_d <= busy_o;
    prog_d <= prog_no;
    if (load) begin
      init_q <= init_start;
      armed  <= 1'b0;
    end else if (busy_o && !busy_d) begin
      cnt <= '0; dly <= d_hi1; tgt <= 1'b1; armed <= (d_hi1 != NEVER);
    end else if (!prog_no && prog_d) begin
      cnt <= '0; dly <= d_lo; tgt <= 1'b0; armed <= (d_lo != NEVER);
    end else if (prog_no && !prog_d) begin
      cnt <= '0; dly <= d_hi2; tgt <= 1'b1; armed <= (d_hi2 != NEVER);
    end else if (armed) begin
      if (cnt == dly) begin
        init_q <= tgt;
        armed  <= 1'b0;
      end else cnt <= cnt + 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic hi, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    @(negedge clk_i);
    init_start = hi; d_hi1 = a; d_lo = b; d_hi2 = c; load = 1'b1;
    @(negedge clk_i);
    load = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    chk("R1 prog", prog_no, 1); chk("R1 busy", busy_o, 0);
    chk("R1 ready", ready_o, 0); chk("R1 err", err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 prog after reset", prog_no, 1);

    // vector walk: R2 R5 R6 R4
    for (int v = 0; v < NVEC; v++) begin
      setup(VECS[v][49], VECS[v][48:33], VECS[v][32:17], VECS[v][16:1]);
      pulse_start();
      chk("R2 busy after start", busy_o, 1);
      wait_idle();
      chk("R5/R6 ready", ready_o, VECS[v][0]);
      chk("R4/R6 err", err_o, !VECS[v][0]);
      chk("R6 prog released", prog_no, 1);
    end

    // R3 level detection with INIT already high
    setup(1'b1, 16'd10, 16'd3, 16'd10);
    pulse_start();
    chk("R2 prog held in phase 1", prog_no, 1);
    @(negedge clk_i);
    chk("R3 prog low one cycle later", prog_no, 0);
    wait_idle();

    // R4 exact poll window
    setup(1'b0, 16'd3, NEVER, 16'd10);
    pulse_start();
    for (int i = 0; i < 100 && prog_no; i++) @(negedge clk_i);
    k = 0;
    // R7 start while busy is ignored
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    k++;
    chk("R7 prog undisturbed", prog_no, 0);
    chk("R7 still busy", busy_o, 1);
    for (int i = 0; i < 200 && !err_o; i++) begin
      @(negedge clk_i);
      k++;
    end
    chk("R4 poll window cycles", k, POLL_MAX * TICK_DIV);

    // R8 sticky error
    repeat (10) @(negedge clk_i);
    chk("R8 err sticky", err_o, 1);
    chk("R9 no ready after err", ready_o, 0);

    // R6 exact timeout, R8 clear on start
    setup(1'b0, NEVER, 16'd3, 16'd10);
    pulse_start();
    chk("R8 err cleared by start", err_o, 0);
    k = 0;
    for (int i = 0; i < 400 && !err_o; i++) begin
      @(negedge clk_i);
      k++;
    end
    chk("R6 timeout cycles", k, TMO_TICKS * TICK_DIV);
    chk("R6 busy low", busy_o, 0);

    // R9 ready after success, then cleared by start
    setup(1'b0, 16'd10, 16'd3, 16'd10);
    pulse_start();
    chk("R9 ready low while busy", ready_o, 0);
    wait_idle();
    chk("R9 ready at end", ready_o, 1);

    // R10 DONE synchroniser
    done_i = 1'b1;
    @(negedge clk_i);
    chk("R10 done after one edge", done_o, 0);
    @(negedge clk_i);
    chk("R10 done after two edges", done_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule